// File: doc/BRIEF.md
# DMA Channel End-of-Transfer Interrupt Status

This block holds the completion status of one DMA channel and turns that status into interrupt requests. It owns the channel's transfer-enable bit, which drives the transfer engine. It also owns two sticky flags. The first records a normal finish, signalled by the engine's counter-reached-zero pulse. The second records an escape finish, raised by any of several abnormal conditions, each of which can be enabled on its own. Both flags, the transfer-enable bit and the per-flag interrupt enables sit behind a small register port.

An end of either kind sets its flag and drops the transfer-enable bit, so the engine stops. The interrupt handler can resume in two ways. It can reload the engine and write 1 to the enable bit, which clears both flags at once. Or it can acknowledge a flag by reading it as 1 and then writing 0 to it. A write of 0 to a flag that has not been seen as 1 does nothing. When a hardware end and a software write land in the same cycle, the hardware end takes priority.

Top module: `dmairq_channel`

## Requirements
- R1: After reset, the transfer-enable bit, both flags, both interrupt enables, all escape enables and both interrupt outputs read 0.
- R2: A counter-zero pulse while the transfer-enable bit is 1 sets the normal-end flag (control register bit 1) and clears the transfer-enable bit (control bit 0) at the same clock edge.
- R3: An escape pulse on input bit i while escape enable bit i (escape register, address 1) is 1 and the transfer-enable bit is 1 sets the escape-end flag (control bit 2) and clears the transfer-enable bit. The input bits are: 0 size error, 1 repeat block end, 2 source repeat-area overflow, 3 destination repeat-area overflow.
- R4: An escape pulse whose enable bit is 0 has no effect. Any end pulse that arrives while the transfer-enable bit is 0 also has no effect.
- R5: Each interrupt output is a register. It goes to 1 one clock after its flag and its enable are both 1: normal-end enable is control bit 3, escape-end enable is control bit 4.
- R6: A write to the control register (address 0) with bit 0 set to 1 clears both flags.
- R7: A write of 0 to a flag bit clears that flag only if the flag was read as 1 since it was last set. Otherwise the write leaves the flag unchanged.
- R8: Read history is discarded whenever a flag is set by hardware or cleared by a transfer-enable write. After that, a flag can be cleared by a write of 0 only after a fresh read.
- R9: A hardware end event in the same cycle as a control write of transfer-enable 1 wins: the flag ends at 1 and the transfer-enable bit ends at 0.
- R10: Software cannot set a flag by writing 1 to it. Writes to unmapped addresses (2, 3) change nothing, and reads from those addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; a read arms the flag acknowledgement |
| reg_addr | input | ADDR_W | Register address (0 control/status, 1 escape enables) |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, combinational from the address |
| cnt_zero | input | 1 | Engine pulse: transfer counter reached zero and the transfer finished |
| esc_evt | input | NUM_ESC | Escape condition pulses, one bit per source |
| xfer_en | output | 1 | Transfer-enable bit driven to the engine |
| irq_done | output | 1 | Registered normal-end interrupt request |
| irq_esc | output | 1 | Registered escape-end interrupt request |

## Verification
The bench builds the block with its defaults: four escape sources, an 8-bit data path, a 2-bit address and a two-stage reset synchronizer. With four sources, every escape input can be triggered one at a time with all enables on, and masked pairs can be tried against partial enable patterns. The 2-bit address leaves two unmapped locations, so the write-ignore and read-zero behaviour can be checked. Same-cycle collisions between an end pulse and a control write are driven on purpose. Read-history behaviour is observed through the registered interrupt outputs, so that the act of checking does not arm an acknowledgement.

// File: rtl/dmairq_pkg.sv
package dmairq_pkg;
  // register addresses
  localparam int unsigned CTL_ADDR = 0;
  localparam int unsigned ESC_ADDR = 1;

  // control/status register bit positions
  localparam int unsigned B_EN      = 0;
  localparam int unsigned B_DONE    = 1;
  localparam int unsigned B_ESC     = 2;
  localparam int unsigned B_DONE_IE = 3;
  localparam int unsigned B_ESC_IE  = 4;
  localparam int unsigned CTL_BITS  = 5;

  // escape source order
  localparam int unsigned ESC_SIZE_ERR = 0;
  localparam int unsigned ESC_RPT_END  = 1;
  localparam int unsigned ESC_SRC_OVF  = 2;
  localparam int unsigned ESC_DST_OVF  = 3;

  typedef struct packed {
    logic esc_ie;
    logic done_ie;
  } irq_en_t;
endpackage

// File: rtl/dmairq_rst_sync.sv
module dmairq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/dmairq_flag.sv
// One sticky end flag with read-before-clear acknowledgement.
module dmairq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic hw_set,   // end event from hardware
  input  logic en_clr,   // transfer-enable written to 1
  input  logic rd_stat,  // status register read
  input  logic wr_stat,  // status register written
  input  logic wr_bit,   // value written to this flag bit
  output logic flag_o
);
  logic flag_q, flag_d;
  logic armed_q, armed_d;
  logic sw_clr;
  logic upd;

  always_comb begin
    sw_clr  = wr_stat & ~wr_bit & armed_q;
    flag_d  = flag_q;
    armed_d = armed_q;
    if (rd_stat && flag_q) begin
      armed_d = 1'b1;
    end
    if (en_clr || sw_clr) begin
      flag_d  = 1'b0;
      armed_d = 1'b0;
    end
    // hardware set has priority over every clear
    if (hw_set) begin
      flag_d  = 1'b1;
      armed_d = 1'b0;
    end
    upd = hw_set | en_clr | sw_clr | rd_stat;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
    end else if (upd) begin
      flag_q  <= flag_d;
      armed_q <= armed_d;
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/dmairq_esc_merge.sv
// Masks each escape source with its own enable and merges them.
module dmairq_esc_merge #(
  parameter int unsigned NUM_ESC = 4
) (
  input  logic [NUM_ESC-1:0] esc_evt,
  input  logic [NUM_ESC-1:0] esc_en,
  input  logic               active,
  output logic               esc_hit
);
  logic [NUM_ESC-1:0] masked;

  for (genvar i = 0; i < NUM_ESC; i++) begin : g_src
    assign masked[i] = esc_evt[i] & esc_en[i];
  end

  assign esc_hit = active & (|masked);
endmodule

// File: rtl/dmairq_channel.sv
module dmairq_channel
  import dmairq_pkg::*;
#(
  parameter int unsigned NUM_ESC    = 4,
  parameter int unsigned ADDR_W     = 2,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned RST_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  input  logic               cnt_zero,
  input  logic [NUM_ESC-1:0] esc_evt,
  output logic               xfer_en,
  output logic               irq_done,
  output logic               irq_esc
);
  localparam int unsigned CTL_PAD = DATA_W - CTL_BITS;
  localparam int unsigned ESC_PAD = DATA_W - NUM_ESC;

  logic rst_sync_n;

  logic ctl_wr, ctl_rd, esc_wr;
  logic done_evt, esc_hit;
  logic en_clr;

  logic               xfer_en_q, xfer_en_d, xfer_en_upd;
  irq_en_t            ie_q, ie_d;
  logic [NUM_ESC-1:0] esc_en_q, esc_en_d;
  logic               done_flag, esc_flag;
  logic               irq_done_q, irq_esc_q, irq_done_d, irq_esc_d;
  logic               unused_wdata;

  dmairq_rst_sync #(.STAGES(RST_STAGES)) u_rst_sync (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_sync_n)
  );

  // register decode
  always_comb begin
    ctl_wr = reg_wr && (reg_addr == ADDR_W'(CTL_ADDR));
    esc_wr = reg_wr && (reg_addr == ADDR_W'(ESC_ADDR));
    ctl_rd = reg_rd && (reg_addr == ADDR_W'(CTL_ADDR));
    en_clr = ctl_wr && reg_wdata[B_EN];
  end

  assign unused_wdata = &{1'b0, reg_wdata};

  // end events only count while the channel is enabled
  assign done_evt = xfer_en_q & cnt_zero;

  dmairq_esc_merge #(.NUM_ESC(NUM_ESC)) u_esc_merge (
    .esc_evt (esc_evt),
    .esc_en  (esc_en_q),
    .active  (xfer_en_q),
    .esc_hit (esc_hit)
  );

  dmairq_flag u_done_flag (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .hw_set  (done_evt),
    .en_clr  (en_clr),
    .rd_stat (ctl_rd),
    .wr_stat (ctl_wr),
    .wr_bit  (reg_wdata[B_DONE]),
    .flag_o  (done_flag)
  );

  dmairq_flag u_esc_flag (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .hw_set  (esc_hit),
    .en_clr  (en_clr),
    .rd_stat (ctl_rd),
    .wr_stat (ctl_wr),
    .wr_bit  (reg_wdata[B_ESC]),
    .flag_o  (esc_flag)
  );

  // next state
  always_comb begin
    xfer_en_d   = xfer_en_q;
    xfer_en_upd = 1'b0;
    if (done_evt || esc_hit) begin
      xfer_en_d   = 1'b0;
      xfer_en_upd = 1'b1;
    end else if (ctl_wr) begin
      xfer_en_d   = reg_wdata[B_EN];
      xfer_en_upd = 1'b1;
    end
    ie_d.done_ie = reg_wdata[B_DONE_IE];
    ie_d.esc_ie  = reg_wdata[B_ESC_IE];
    esc_en_d     = reg_wdata[NUM_ESC-1:0];
    irq_done_d   = ie_q.done_ie & done_flag;
    irq_esc_d    = ie_q.esc_ie & esc_flag;
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      xfer_en_q <= 1'b0;
    end else if (xfer_en_upd) begin
      xfer_en_q <= xfer_en_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ie_q <= '0;
    end else if (ctl_wr) begin
      ie_q <= ie_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      esc_en_q <= '0;
    end else if (esc_wr) begin
      esc_en_q <= esc_en_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      irq_done_q <= 1'b0;
      irq_esc_q  <= 1'b0;
    end else begin
      irq_done_q <= irq_done_d;
      irq_esc_q  <= irq_esc_d;
    end
  end

  // read mux
  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_W'(CTL_ADDR)) begin
      reg_rdata = {{CTL_PAD{1'b0}}, ie_q.esc_ie, ie_q.done_ie, esc_flag, done_flag, xfer_en_q};
    end else if (reg_addr == ADDR_W'(ESC_ADDR)) begin
      reg_rdata = {{ESC_PAD{1'b0}}, esc_en_q};
    end
  end

  assign xfer_en  = xfer_en_q;
  assign irq_done = irq_done_q;
  assign irq_esc  = irq_esc_q;
endmodule

// File: rtl/dmairq_chk.sv
module dmairq_chk #(
  parameter int unsigned NUM_ESC = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               xfer_en,
  input logic               done_flag,
  input logic               esc_flag,
  input logic               done_ie,
  input logic               esc_ie,
  input logic               irq_done,
  input logic               irq_esc,
  input logic               cnt_zero,
  input logic [NUM_ESC-1:0] esc_evt,
  input logic [NUM_ESC-1:0] esc_en,
  input logic               ctl_wr,
  input logic               wr_en_bit
);
  logic any_esc;
  assign any_esc = |(esc_evt & esc_en);

  // R2
  done_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_en && cnt_zero) |=> (done_flag && !xfer_en));

  // R3
  esc_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_en && any_esc) |=> (esc_flag && !xfer_en));

  // R4
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!xfer_en && !esc_flag && !done_flag) |=> (!esc_flag && !done_flag));

  // R5
  irq_done_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_done == $past(done_ie && done_flag));

  // R5
  irq_esc_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_esc == $past(esc_ie && esc_flag));

  // R6
  en_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && wr_en_bit && !(xfer_en && (cnt_zero || any_esc)))
      |=> (!done_flag && !esc_flag));
endmodule

bind dmairq_channel dmairq_chk #(.NUM_ESC(NUM_ESC)) u_dmairq_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .xfer_en   (xfer_en_q),
  .done_flag (done_flag),
  .esc_flag  (esc_flag),
  .done_ie   (ie_q.done_ie),
  .esc_ie    (ie_q.esc_ie),
  .irq_done  (irq_done),
  .irq_esc   (irq_esc),
  .cnt_zero  (cnt_zero),
  .esc_evt   (esc_evt),
  .esc_en    (esc_en_q),
  .ctl_wr    (ctl_wr),
  .wr_en_bit (reg_wdata[0])
);

// File: tb/test_dmairq_channel.sv
module test_dmairq_channel;
  localparam int unsigned NUM_ESC = 4;
  localparam int unsigned ADDR_W  = 2;
  localparam int unsigned DATA_W  = 8;

  logic               clk;
  logic               rst_n;
  logic               reg_wr, reg_rd;
  logic [ADDR_W-1:0]  reg_addr;
  logic [DATA_W-1:0]  reg_wdata;
  logic [DATA_W-1:0]  reg_rdata;
  logic               cnt_zero;
  logic [NUM_ESC-1:0] esc_evt;
  logic               xfer_en, irq_done, irq_esc;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  dmairq_channel #(.NUM_ESC(NUM_ESC), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_dmairq_channel (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cnt_zero(cnt_zero), .esc_evt(esc_evt),
    .xfer_en(xfer_en), .irq_done(irq_done), .irq_esc(irq_esc)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = ADDR_W'(a); reg_wdata = DATA_W'(d);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [DATA_W-1:0] v);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = ADDR_W'(a);
    #1 v = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic pulse(input logic cz, input logic [NUM_ESC-1:0] ev);
    @(negedge clk);
    cnt_zero = cz; esc_evt = ev;
    @(negedge clk);
    cnt_zero = 1'b0; esc_evt = '0;
  endtask

  task automatic t_reset();
    logic [DATA_W-1:0] v;
    rd(0, v); chk("R1 control", v, 0);
    rd(1, v); chk("R1 escape enables", v, 0);
    chk("R1 xfer_en", xfer_en, 0);
    chk("R1 irqs", {irq_done, irq_esc}, 0);
  endtask

  task automatic t_done();
    logic [DATA_W-1:0] v;
    wr(0, 'h09);
    chk("R2 enabled", xfer_en, 1);
    pulse(1'b1, '0);
    chk("R2 xfer_en dropped", xfer_en, 0);
    chk("R5 irq_done not yet", irq_done, 0);
    @(negedge clk);
    chk("R5 irq_done one cycle later", irq_done, 1);
    chk("R5 irq_esc quiet", irq_esc, 0);
    rd(0, v); chk("R2 status", v, 'h0A);
    wr(0, 'h00);
  endtask

  task automatic t_escape();
    logic [DATA_W-1:0] v;
    wr(1, 'h0F);
    for (int i = 0; i < NUM_ESC; i++) begin
      wr(0, 'h11);
      pulse(1'b0, NUM_ESC'(1) << i);
      rd(0, v); chk($sformatf("R3 source %0d status", i), v, 'h14);
      chk("R5 irq_esc", irq_esc, 1);
    end
    wr(0, 'h00);
  endtask

  task automatic t_masked();
    logic [DATA_W-1:0] v;
    wr(1, 'h05);
    wr(0, 'h01);
    pulse(1'b0, 4'b1010);
    rd(0, v); chk("R4 masked sources", v, 'h01);
    wr(0, 'h00);
    pulse(1'b1, 4'b1111);
    rd(0, v); chk("R4 idle ignores events", v, 'h00);
    wr(1, 'h0F);
  endtask

  task automatic t_enable_clears();
    logic [DATA_W-1:0] v;
    wr(0, 'h01);
    pulse(1'b1, 4'b0001);
    rd(0, v); chk("R6 both flags set", v, 'h06);
    wr(0, 'h01);
    rd(0, v); chk("R6 enable write clears flags", v, 'h01);
    wr(0, 'h00);
  endtask

  task automatic t_sw_clear();
    logic [DATA_W-1:0] v;
    wr(0, 'h01);
    pulse(1'b1, '0);
    wr(0, 'h00);
    rd(0, v); chk("R7 write 0 without read ignored", v, 'h02);
    wr(0, 'h00);
    rd(0, v); chk("R7 write 0 after read clears", v, 'h00);
    wr(0, 'h06);
    rd(0, v); chk("R10 no software set", v, 'h00);
  endtask

  task automatic t_history();
    logic [DATA_W-1:0] v;
    wr(0, 'h09);
    pulse(1'b1, '0);
    rd(0, v); chk("R8 first end", v, 'h0A);
    wr(0, 'h09);
    chk("R8 re-enabled", xfer_en, 1);
    pulse(1'b1, '0);
    wr(0, 'h08);
    @(negedge clk);
    chk("R8 stale read cannot clear", irq_done, 1);
    rd(0, v);
    wr(0, 'h00);
    @(negedge clk);
    chk("R8 fresh read then clear", irq_done, 0);
  endtask

  task automatic t_set_wins();
    logic [DATA_W-1:0] v;
    wr(0, 'h01);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 0; reg_wdata = 'h01; cnt_zero = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; cnt_zero = 1'b0;
    chk("R9 xfer_en lost to end", xfer_en, 0);
    rd(0, v); chk("R9 flag kept", v, 'h02);
    wr(0, 'h00);
  endtask

  task automatic t_unmapped();
    logic [DATA_W-1:0] v;
    wr(0, 'h18);
    wr(2, 'hFF);
    wr(3, 'hFF);
    rd(2, v); chk("R10 unmapped read 0", v, 0);
    rd(0, v); chk("R10 control untouched", v, 'h18);
    rd(1, v); chk("R10 escape enables untouched", v, 'h0F);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = '0; reg_wdata = '0;
    cnt_zero = 1'b0; esc_evt = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_done();
    t_escape();
    t_masked();
    t_enable_clears();
    t_sw_clear();
    t_history();
    t_set_wins();
    t_unmapped();
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule